// File: doc/BRIEF.md
# Per-Core Tick Event Timer

This block is a countdown event timer meant to be instantiated once per processor core. A prescaler stage turns the input clock into a slower tick stream, and an event counter behind it counts those ticks. When the event counter runs out, an interrupt status flag latches and, if enabled, drives the interrupt line.

Software programs the block through a simple register write port and a combinational read port, both addressed by a byte offset. In one-shot use the event counter disarms itself when it expires. In interval use it reloads and fires again after every period until software stops it. Every write to a count or control register is confirmed by its own write-acknowledge bit, so a driver can poll for it.

Top module: `core_tick_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The prescale register at offset 0x00 holds a value B, and the prescaler produces one tick every B+1 clock cycles while the tick-run bit (bit 0 of the control register at offset 0x20) is set.
- R3: The event counter holds a value N of at least 1. It ticks while the event-run bit (bit 1 of control) is set. The status flag (bit 0 at offset 0x30) becomes visible exactly N*(B+1) clock edges after the control write that sets both run bits.
- R4: With the interval bit (bit 2 of control) set, the event counter reloads on expiry and the status flag sets again every N*(B+1) cycles. The control bits stay unchanged.
- R5: With the interval bit clear, expiry clears the event-run bit. The tick-run bit stays set, and no further event occurs until software restarts the counter.
- R6: A write to the event count register at offset 0x08 takes the low 31 bits as the new count only if bit 31 of the write data is 1. A write with bit 31 clear leaves the stored count unchanged. A read returns the stored count with bit 31 as 0.
- R7: Writing 1 to bit 0 of offset 0x30 clears the status flag; an expiry in the same cycle wins. `irq` equals the status flag ANDed with the enable bit (bit 0 at offset 0x34).
- R8: Clearing a run bit halts its counter at once, so no event is raised. Setting a run bit again reloads its counter from the stored value, so the next period is complete.
- R9: The write-acknowledge register at offset 0x40 sets bit 0 after a prescale write, bit 1 after an event count write and bit 3 after a control write. A bit becomes visible on the second clock edge after the write is sampled. Writing 1 to a bit clears it, and a new set wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, sampled on the rising clock edge |
| reg_addr | input | 8 | Byte offset of the register being written |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 8 | Byte offset of the register being read |
| reg_rdata | output | 32 | Read data, combinational from `reg_raddr` |
| irq | output | 1 | Event interrupt request, level |

## Verification
The assertions assume that `reg_addr` and `reg_wdata` are only meaningful while `reg_we` is high. They also assume that software never rewrites the prescale value while the tick stage runs; the bench always stops both run bits before it reprograms a count. The bench sweeps prescale values 0 to 3 and event counts 1 to 4, and in interval mode it keeps every period at four cycles or more. This leaves room for the status-clear write to complete before the next expiry, so each latched event is seen on its own.

// File: rtl/core_tick_timer.sv
module core_tick_timer #(
  parameter int TICK_W = 32,
  parameter int ICNT_W = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic [7:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        irq
);

  localparam logic [7:0] A_PRESC = 8'h00;
  localparam logic [7:0] A_EVCNT = 8'h08;
  localparam logic [7:0] A_CTRL  = 8'h20;
  localparam logic [7:0] A_STAT  = 8'h30;
  localparam logic [7:0] A_ENAB  = 8'h34;
  localparam logic [7:0] A_WACK  = 8'h40;

  logic [TICK_W-1:0] presc_val, presc_cnt;
  logic [ICNT_W-1:0] ev_val, ev_cnt;
  logic [2:0]        ctrl, ctrl_nx;
  logic              int_stat, int_en;
  logic [3:0]        wack, wack_pend, wack_hit;
  logic              tick, expire, tick_go, ev_go;

  wire wr_presc = reg_we && reg_addr == A_PRESC;
  wire wr_evcnt = reg_we && reg_addr == A_EVCNT;
  wire wr_ctrl  = reg_we && reg_addr == A_CTRL;
  wire wr_stat  = reg_we && reg_addr == A_STAT;
  wire wr_enab  = reg_we && reg_addr == A_ENAB;
  wire wr_wack  = reg_we && reg_addr == A_WACK;

  assign tick   = ctrl[0] && presc_cnt == '0;
  assign expire = ctrl[1] && tick && ev_cnt <= ICNT_W'(1);
  assign irq    = int_stat & int_en;

  always_comb begin
    ctrl_nx = ctrl;
    if (expire && !ctrl[2]) ctrl_nx[1] = 1'b0;
    if (wr_ctrl) ctrl_nx = reg_wdata[2:0];
  end

  assign tick_go = ctrl_nx[0] & ~ctrl[0];
  assign ev_go   = ctrl_nx[1] & ~ctrl[1];
  assign wack_hit = {wr_ctrl, 1'b0, wr_evcnt, wr_presc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_val <= '0;
      ev_val    <= '0;
      ctrl      <= '0;
      int_en    <= 1'b0;
    end else begin
      if (wr_presc) presc_val <= reg_wdata[TICK_W-1:0];
      if (wr_evcnt && reg_wdata[31]) ev_val <= reg_wdata[ICNT_W-1:0];
      if (wr_enab) int_en <= reg_wdata[0];
      ctrl <= ctrl_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_cnt <= '0;
    else if (tick_go) presc_cnt <= presc_val;
    else if (ctrl[0]) presc_cnt <= (presc_cnt == '0) ? presc_val : presc_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_cnt <= '0;
    else if (ev_go) ev_cnt <= ev_val;
    else if (ctrl[1] && tick) ev_cnt <= expire ? ev_val : ev_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_stat <= 1'b0;
    else if (expire) int_stat <= 1'b1;
    else if (wr_stat && reg_wdata[0]) int_stat <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wack_pend <= '0;
      wack      <= '0;
    end else begin
      wack_pend <= wack_hit;
      wack      <= (wack & ~(wr_wack ? reg_wdata[3:0] : 4'b0)) | wack_pend;
    end
  end

  always_comb begin
    case (reg_raddr)
      A_PRESC: reg_rdata = 32'(presc_val);
      A_EVCNT: reg_rdata = 32'(ev_val);
      A_CTRL:  reg_rdata = {29'b0, ctrl};
      A_STAT:  reg_rdata = {31'b0, int_stat};
      A_ENAB:  reg_rdata = {31'b0, int_en};
      A_WACK:  reg_rdata = {28'b0, wack};
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/core_tick_timer_chk.sv
module core_tick_timer_chk #(
  parameter int TICK_W = 32,
  parameter int ICNT_W = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [7:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              irq,
  input logic              int_en,
  input logic              int_stat,
  input logic [2:0]        ctrl,
  input logic [TICK_W-1:0] presc_cnt,
  input logic [ICNT_W-1:0] ev_val,
  input logic [3:0]        wack,
  input logic              expire
);

  wire ctrl_wr = reg_we && reg_addr == 8'h20;

  a_r3_status_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> int_stat);

  a_r5_oneshot_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl[2] && !ctrl_wr) |=> !ctrl[1]);

  a_r4_interval_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl[2] && !ctrl_wr) |=> ctrl[1]);

  a_r8_prescaler_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !ctrl_wr) |=> $stable(presc_cnt));

  a_r6_flagless_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 8'h08 && !reg_wdata[31]) |=> $stable(ev_val));

  a_r9_presc_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 8'h00) |-> ##2 wack[0]);

  a_r9_ctrl_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |-> ##2 wack[3]);

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int_en && int_stat));

endmodule

bind core_tick_timer core_tick_timer_chk #(.TICK_W(TICK_W), .ICNT_W(ICNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .int_en(int_en), .int_stat(int_stat),
  .ctrl(ctrl), .presc_cnt(presc_cnt), .ev_val(ev_val), .wack(wack),
  .expire(expire)
);

// File: tb/core_tick_timer_test.sv
`timescale 1ns/1ps
module core_tick_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  core_tick_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_irq(input int lim, output int t);
    int n = 0;
    while (!irq && n < lim) begin
      @(negedge clk);
      n++;
    end
    t = cyc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    $display("FAIL watchdog: actual timeout expected completion");
    n_cmp++; n_bad++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int t0, t1, t2;

    idle(3);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", irq, 0);
    rd(8'h20, d); check("R1 ctrl", d, 0);
    rd(8'h30, d); check("R1 status", d, 0);
    rd(8'h40, d); check("R1 wack", d, 0);
    rd(8'h00, d); check("R1 prescale", d, 0);

    // R9 write acknowledge timing and clearing
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h00; reg_wdata = 32'd2;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    rd(8'h40, d); check("R9 ack after one edge", d[0], 0);
    @(negedge clk);
    rd(8'h40, d); check("R9 ack after two edges", d[0], 1);
    wr(8'h40, 32'h1);
    rd(8'h40, d); check("R9 ack cleared", d, 0);
    wr(8'h08, 32'h8000_0001);
    wr(8'h20, 32'h0);
    idle(2);
    rd(8'h40, d); check("R9 event and control acks", d, 32'hA);
    wr(8'h40, 32'hF);
    rd(8'h40, d); check("R9 all acks cleared", d, 0);

    wr(8'h34, 32'h1);

    // R2 R3 R5 one-shot sweep
    for (int b = 0; b < 4; b++) begin
      for (int n = 1; n < 5; n++) begin
        wr(8'h20, 32'h0);
        wr(8'h00, b);
        wr(8'h08, 32'h8000_0000 | n);
        wr(8'h30, 32'h1);
        wr(8'h20, 32'h3);
        t0 = cyc;
        wait_irq(100, t1);
        check("R2 R3 one-shot period", t1 - t0, n * (b + 1));
        rd(8'h20, d); check("R5 event-run cleared", d, 1);
        wr(8'h30, 32'h1);
        idle(n * (b + 1) + 4);
        check("R5 no repeat", irq, 0);
      end
    end

    // R4 interval sweep
    for (int b = 1; b < 4; b++) begin
      for (int n = 2; n < 5; n++) begin
        wr(8'h20, 32'h0);
        wr(8'h00, b);
        wr(8'h08, 32'h8000_0000 | n);
        wr(8'h30, 32'h1);
        wr(8'h20, 32'h7);
        t0 = cyc;
        wait_irq(100, t1);
        check("R4 first period", t1 - t0, n * (b + 1));
        wr(8'h30, 32'h1);
        wait_irq(100, t2);
        check("R4 second period", t2 - t1, n * (b + 1));
        rd(8'h20, d); check("R4 control kept", d, 7);
      end
    end

    // R6 update flag
    wr(8'h20, 32'h0);
    wr(8'h30, 32'h1);
    wr(8'h00, 32'd1);
    wr(8'h08, 32'h8000_0003);
    wr(8'h08, 32'h0000_0007);
    rd(8'h08, d); check("R6 flagless write ignored", d, 3);
    wr(8'h20, 32'h3);
    t0 = cyc;
    wait_irq(100, t1);
    check("R6 period uses stored count", t1 - t0, 6);

    // R8 stop halts, restart reloads
    wr(8'h20, 32'h0);
    wr(8'h30, 32'h1);
    wr(8'h00, 32'd3);
    wr(8'h08, 32'h8000_0004);
    wr(8'h20, 32'h3);
    idle(5);
    wr(8'h20, 32'h0);
    idle(40);
    check("R8 stopped no irq", irq, 0);
    rd(8'h30, d); check("R8 stopped no status", d, 0);
    wr(8'h20, 32'h3);
    t0 = cyc;
    wait_irq(100, t1);
    check("R8 full period after restart", t1 - t0, 16);

    // R7 enable gating and status clear
    wr(8'h20, 32'h0);
    wr(8'h30, 32'h1);
    wr(8'h34, 32'h0);
    wr(8'h00, 32'd0);
    wr(8'h08, 32'h8000_0002);
    wr(8'h20, 32'h3);
    idle(10);
    check("R7 masked irq", irq, 0);
    rd(8'h30, d); check("R7 status latched", d, 1);
    wr(8'h34, 32'h1);
    check("R7 irq when enabled", irq, 1);
    wr(8'h30, 32'h1);
    check("R7 irq after clear", irq, 0);
    rd(8'h30, d); check("R7 status after clear", d, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule